// File: doc/BRIEF.md
# Radix-4 Logarithmic Left Shifter

A purely combinational left shifter for a parameterised word width `W` (a power of two). The shift amount is `log2(W)` bits wide. The shift is built from a chain of stages. Each stage takes one pair of shift-amount bits and drives a 4:1 multiplexer per output bit. The four choices of the stage for pair `k` are shifts by 0, m, 2m and 3m, where m = 4^k.

When `log2(W)` is odd, the most significant shift-amount bit is left over after pairing. One 2:1 stage handles it with a distance of W/2. Vacated low positions fill with zeros, and bits pushed past the top are dropped. The output has the same width as the input and follows the inputs within the same cycle. There are no registers.

Top module: `shl_radix4`

## Requirements
- R1: With a shift amount of zero, `data_o` equals `data_i` bit for bit.
- R2: At W=32 (5-bit amount, so two radix-4 stages plus one radix-2 stage), `data_o` equals `data_i` shifted left by `amt_i` for every amount from 0 to 31.
- R3: For a shift amount a, the output bits [a-1:0] are all zero.
- R4: Input bits that would land at position W or above are discarded. An all-ones input shifted by a leaves exactly W-a ones.
- R5: At W=16 (4-bit amount, only radix-4 stages), `data_o` equals `data_i << amt_i` for every amount.
- R6: At W=8 (3-bit amount, one radix-4 stage plus one radix-2 stage), `data_o` equals `data_i << amt_i` for every amount.
- R7: At an odd amount width, an amount with only its most significant bit set shifts by exactly W/2.
- R8: The output settles in the same cycle as an input change, with no clock or register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | W | Word to shift |
| amt_i | input | $clog2(W) | Left shift distance, unsigned |
| data_o | output | W | Shifted word, zero-filled from below |

## Verification
The hardest case to reach is the leftover radix-2 stage when it combines with high digits in the pair stages. Amounts such as 16+15 at W=32 or 4+3 at W=8 push data through every stage at its largest distance at once. Stepping through every amount with several data patterns reaches each such combination. This includes a pattern with both end bits set, which shows discards at the top and zero fill at the bottom in the same word. The same stimulus drives instances at widths 8, 16 and 32 side by side, so the odd and even stage layouts are compared against the same expectations.

// File: rtl/shl_pkg.sv
package shl_pkg;
  typedef enum logic [1:0] {
    SEL_D0 = 2'd0,
    SEL_D1 = 2'd1,
    SEL_D2 = 2'd2,
    SEL_D3 = 2'd3
  } r4_sel_e;

  function automatic int unsigned pair_dist(input int unsigned k);
    return 32'd1 << (2 * k);
  endfunction
endpackage

// File: rtl/shl_r4_stage.sv
module shl_r4_stage
  import shl_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned M = 1
) (
  input  logic [W-1:0] data_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sh_m, sh_2m, sh_3m;

  assign sh_m  = data_i << M;
  assign sh_2m = data_i << (2 * M);
  assign sh_3m = data_i << (3 * M);

  always_comb begin
    unique case (r4_sel_e'(sel_i))
      SEL_D0:  data_o = data_i;
      SEL_D1:  data_o = sh_m;
      SEL_D2:  data_o = sh_2m;
      SEL_D3:  data_o = sh_3m;
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/shl_r2_stage.sv
module shl_r2_stage #(
  parameter int unsigned W = 32,
  parameter int unsigned M = 16
) (
  input  logic [W-1:0] data_i,
  input  logic         sel_i,
  output logic [W-1:0] data_o
);
  assign data_o = sel_i ? (data_i << M) : data_i;
endmodule

// File: rtl/shl_radix4.sv
module shl_radix4
  import shl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]         data_i,
  input  logic [$clog2(W)-1:0] amt_i,
  output logic [W-1:0]         data_o
);
  localparam int unsigned AMT_W   = $clog2(W);
  localparam int unsigned N_PAIRS = AMT_W / 2;
  localparam bit          HAS_R2  = (AMT_W % 2) == 1;

  // chain[k] is the word after k pair stages
  logic [W-1:0] chain [N_PAIRS+1];
  assign chain[0] = data_i;

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
    shl_r4_stage #(
      .W (W),
      .M (pair_dist(k))
    ) u_stage (
      .data_i (chain[k]),
      .sel_i  (amt_i[2*k+1 -: 2]),
      .data_o (chain[k+1])
    );
  end

  if (HAS_R2) begin : g_tail
    // leftover top amount bit, weight W/2
    shl_r2_stage #(
      .W (W),
      .M (W / 2)
    ) u_tail (
      .data_i (chain[N_PAIRS]),
      .sel_i  (amt_i[AMT_W-1]),
      .data_o (data_o)
    );
  end else begin : g_no_tail
    assign data_o = chain[N_PAIRS];
  end
endmodule

// File: rtl/shl_radix4_chk.sv
module shl_radix4_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0]         data_i,
  input logic [$clog2(W)-1:0] amt_i,
  input logic [W-1:0]         data_o
);
  localparam int unsigned AMT_W = $clog2(W);

  logic [W-1:0] low_mask;
  assign low_mask = (W'(1) << amt_i) - W'(1);

  always_comb begin
    if (amt_i == '0)
      p_zero_pass_r1: assert (data_o == data_i)
        else $error("R1 zero amount altered data");
    p_low_clear_r3: assert ((data_o & low_mask) == '0)
      else $error("R3 vacated bits not zero");
    p_ones_bound_r4: assert ($countones(data_o) <= $countones(data_i))
      else $error("R4 output gained ones");
    p_top_bit_r2: assert (data_o[W-1] == data_i[W-1-int'(amt_i)])
      else $error("R2 top bit mismatch");
    if ((AMT_W % 2) == 1 && amt_i == AMT_W'(W / 2))
      p_tail_dist_r7: assert (data_o == (data_i << (W / 2)))
        else $error("R7 leftover stage distance wrong");
  end
endmodule

bind shl_radix4 shl_radix4_chk #(.W(W)) u_chk (
  .data_i (data_i),
  .amt_i  (amt_i),
  .data_o (data_o)
);

// File: tb/shl_radix4_tb.sv
module shl_radix4_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] d32, q32;
  logic [4:0]  a32;
  logic [15:0] d16, q16;
  logic [3:0]  a16;
  logic [7:0]  d8, q8;
  logic [2:0]  a8;

  shl_radix4 #(.W(32)) u_dut     (.data_i(d32), .amt_i(a32), .data_o(q32));
  shl_radix4 #(.W(16)) u_dut_w16 (.data_i(d16), .amt_i(a16), .data_o(q16));
  shl_radix4 #(.W(8))  u_dut_w8  (.data_i(d8),  .amt_i(a8),  .data_o(q8));

  typedef struct {
    logic [31:0] e32;
    logic [15:0] e16;
    logic [7:0]  e8;
    logic [4:0]  amt;
    logic        ones;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] d, input logic [4:0] a);
    item_t it;
    @(negedge clk);
    d32 = d;            a32 = a;
    d16 = d[15:0];      a16 = a[3:0];
    d8  = d[7:0];       a8  = a[2:0];
    it.e32 = d << a;
    it.e16 = d[15:0] << a[3:0];
    it.e8  = d[7:0] << a[2:0];
    it.amt = a;
    it.ones = (d == 32'hFFFF_FFFF);
    sb_q.push_back(it);
  endtask

  // monitor: sample half a cycle after drive (R8: same-cycle settle)
  initial begin
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] lm;
        it = sb_q.pop_front();
        lm = (32'd1 << it.amt) - 32'd1;
        if (it.amt == 5'd0) chk(q32 == d32, "R1", q32, d32);
        if (it.amt == 5'd16) chk(q32 == it.e32, "R7", q32, it.e32);
        if (it.amt[2:0] == 3'd4) chk(q8 == it.e8, "R7", {24'd0, q8}, {24'd0, it.e8});
        chk(q32 == it.e32, "R2", q32, it.e32);
        chk(q16 == it.e16, "R5", {16'd0, q16}, {16'd0, it.e16});
        chk(q8 == it.e8, "R6", {24'd0, q8}, {24'd0, it.e8});
        chk((q32 & lm) == 32'd0, "R3", q32 & lm, 32'd0);
        if (it.ones)
          chk($countones(q32) == 32 - int'(it.amt), "R4", $countones(q32), 32 - int'(it.amt));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'h0000_0001;
    pats[2] = 32'h8000_0001;
    pats[3] = 32'hA5C3_0F96;
    pats[4] = 32'h1234_5678;
    pats[5] = 32'h0F0F_F0F0;
    d32 = '0; a32 = '0; d16 = '0; a16 = '0; d8 = '0; a8 = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(q32 == 32'd0, "R1", q32, 32'd0);  // idle state under reset
    rst_ni = 1'b1;
    for (int p = 0; p < 6; p++)
      for (int a = 0; a < 32; a++)
        drive(pats[p], 5'(a));
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule